// File: doc/BRIEF.md
# Clock Controller Register File

This block is the software-visible configuration store of a clock control unit. It keeps twenty-six 32-bit words in a 4 KB byte-addressed window. Each word takes a fixed value when reset is asserted. The clock tree reads the mode word, the two post-divider words, the main and system PLL control words and the three gating words directly from output ports.

A single request interface carries reads and writes. The inputs are a valid strobe, a write flag, a byte address and write data. Read data is registered. Eight of the words can be written, and each of those passes its written value through its own bit mask. The mode word also has one bit that every write sets.

Any access the block cannot honour gives a one-cycle error pulse. That covers a write to a word that cannot be written, a write to an unknown offset, and a read beyond the last word. These accesses change no stored state.

Top module: `clkctl_regfile`

## Requirements
- R1: On reset, word 0 holds 0x074b0b7d, word 1 holds 0xff870b48, and words 8, 9, 10 and 11 hold 0xffffffff. Every other word holds zero. rsp_rdata and rsp_err are zero.
- R2: The word index is req_addr shifted right by two. The two low address bits have no effect on which word is read or written.
- R3: A read of an index below 26 puts that word on rsp_rdata in the cycle after the request. rsp_rdata then keeps that value until the next read, and writes do not disturb it.
- R4: A read of an index of 26 or above returns zero on rsp_rdata and raises rsp_err.
- R5: A write to word 0 stores the write data ANDed with 0x3b6fdfff, with bit 26 always set to 1.
- R6: A write to word 1 stores the data ANDed with 0xff9f3fff. A write to word 4 or word 6 stores the data ANDed with 0xbfff3fff.
- R7: A write to word 2, 8, 9 or 10 stores all 32 written bits.
- R8: A write to any other index, either a read-only word (3, 5, 7, 11 to 25) or an index of 26 or above, changes no stored word and raises rsp_err.
- R9: rsp_err is high for exactly the cycle after an offending access. It is low after an accepted read or write.
- R10: The clock-tree outputs show the current contents of words 0, 1, 2, 4 and 6 and of the gate words 10, 9 and 8. Each output reflects a write from the cycle after it.
- R11: A cycle with req_valid low changes no word, keeps rsp_rdata, and leaves rsp_err low, whatever the other request inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | One-cycle error pulse |
| clk_mode_o | output | 32 | Word 0, clock mode control |
| clk_div_a_o | output | 32 | Word 1, first post-divider set |
| clk_div_b_o | output | 32 | Word 2, second post-divider set |
| clk_pll_main_o | output | 32 | Word 4, main PLL control |
| clk_pll_sys_o | output | 32 | Word 6, system PLL control |
| clk_gate_o | output | 96 | Gate words {10, 9, 8}, word 8 in bits 31:0 |

## Verification
The bench builds the block with ADDR_W = 12 and NUM_REGS = 26. With these values the 10-bit index reaches every code up to 1023, so both the read error path and the write error path get exercised past the last word. With 26 words, the 5-bit read select has six spare codes, 26 to 31. The bench reads and writes all six to show that they do not alias onto real words. At each step, the bench's behavioural model predicts rsp_rdata, rsp_err and all eight clock-tree words, and these are compared every cycle.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   localparam int unsigned WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;

   // Word indices that the clock tree decodes.
   localparam int unsigned IDX_MODE     = 0;
   localparam int unsigned IDX_DIV_A    = 1;
   localparam int unsigned IDX_DIV_B    = 2;
   localparam int unsigned IDX_PLL_MAIN = 4;
   localparam int unsigned IDX_PLL_SYS  = 6;
   localparam int unsigned IDX_GATE0    = 8;
   localparam int unsigned IDX_GATE1    = 9;
   localparam int unsigned IDX_GATE2    = 10;
   localparam int unsigned IDX_WAKE_MSK = 11;
   localparam int unsigned MIN_REGS     = IDX_WAKE_MSK + 1;
   localparam int unsigned GATE_WORDS   = 3;

   localparam int unsigned MODE_FORCE_BIT = 26;
   localparam word_t MODE_WR_MASK  = 32'h3b6f_dfff;
   localparam word_t DIV_A_WR_MASK = 32'hff9f_3fff;
   localparam word_t PLL_WR_MASK   = 32'hbfff_3fff;
   localparam word_t MODE_RST      = 32'h074b_0b7d;
   localparam word_t DIV_A_RST     = 32'hff87_0b48;
   localparam word_t ALL_ONES      = '1;

   typedef struct packed {
      logic  wr_en;
      word_t mask;
      word_t force1;
      word_t rst;
   } reg_attr_t;

   // Per-word attributes: writability, write mask, forced ones, reset value.
   function automatic reg_attr_t reg_attr(input int unsigned idx);
      reg_attr_t a;
      a.wr_en  = 1'b0;
      a.mask   = '0;
      a.force1 = '0;
      a.rst    = '0;
      case (idx)
         IDX_MODE: begin
            a.wr_en  = 1'b1;
            a.mask   = MODE_WR_MASK;
            a.force1 = word_t'(1) << MODE_FORCE_BIT;
            a.rst    = MODE_RST;
         end
         IDX_DIV_A: begin
            a.wr_en = 1'b1;
            a.mask  = DIV_A_WR_MASK;
            a.rst   = DIV_A_RST;
         end
         IDX_DIV_B: begin
            a.wr_en = 1'b1;
            a.mask  = ALL_ONES;
         end
         IDX_PLL_MAIN, IDX_PLL_SYS: begin
            a.wr_en = 1'b1;
            a.mask  = PLL_WR_MASK;
         end
         IDX_GATE0, IDX_GATE1, IDX_GATE2: begin
            a.wr_en = 1'b1;
            a.mask  = ALL_ONES;
            a.rst   = ALL_ONES;
         end
         IDX_WAKE_MSK: begin
            a.rst = ALL_ONES;
         end
         default: ;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/clkctl_addr_dec.sv
module clkctl_addr_dec
   import clkctl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned NUM_REGS = 26,
   parameter int unsigned SEL_W    = 5
) (
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                wr_acc_i,
   output logic                in_range_o,
   output logic [SEL_W-1:0]    sel_o,
   output logic [NUM_REGS-1:0] wr_sel_o
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             unused_lo;

   assign idx        = addr_i[ADDR_W-1:2];
   assign unused_lo  = ^addr_i[1:0];
   assign in_range_o = (32'(idx) < NUM_REGS);
   assign sel_o      = idx[SEL_W-1:0];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_wsel
      localparam reg_attr_t ATTR = reg_attr(i);
      if (ATTR.wr_en) begin : g_wr
         assign wr_sel_o[i] = wr_acc_i && (32'(idx) == i);
      end else begin : g_ro
         assign wr_sel_o[i] = 1'b0;
      end
   end

endmodule

// File: rtl/clkctl_word.sv
module clkctl_word
   import clkctl_pkg::*;
#(
   parameter word_t RST_VAL    = '0,
   parameter word_t WR_MASK    = '1,
   parameter word_t FORCE_ONES = '0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_i,
   input  word_t wdata_i,
   output word_t q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= RST_VAL;
      end else if (wr_i) begin
         q_o <= (wdata_i & WR_MASK) | FORCE_ONES;
      end
   end

endmodule

// File: rtl/clkctl_resp.sv
module clkctl_resp
   import clkctl_pkg::*;
#(
   parameter int unsigned NUM_REGS = 26,
   parameter int unsigned SEL_W    = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_i,
   input  logic                     in_range_i,
   input  logic [SEL_W-1:0]         sel_i,
   input  word_t [NUM_REGS-1:0]     words_i,
   input  logic                     bad_i,
   output word_t                    rdata_o,
   output logic                     err_o
);

   word_t rd_word;

   always_comb begin
      rd_word = '0;
      if (in_range_i) begin
         rd_word = words_i[sel_i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
         err_o   <= 1'b0;
      end else begin
         err_o <= bad_i;
         if (rd_i) begin
            rdata_o <= rd_word;
         end
      end
   end

endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
   import clkctl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned NUM_REGS = 26
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic                       req_write,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [WORD_W-1:0]          req_wdata,
   output logic [WORD_W-1:0]          rsp_rdata,
   output logic                       rsp_err,
   output logic [WORD_W-1:0]          clk_mode_o,
   output logic [WORD_W-1:0]          clk_div_a_o,
   output logic [WORD_W-1:0]          clk_div_b_o,
   output logic [WORD_W-1:0]          clk_pll_main_o,
   output logic [WORD_W-1:0]          clk_pll_sys_o,
   output logic [GATE_WORDS*WORD_W-1:0] clk_gate_o
);

   localparam int unsigned SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   if (NUM_REGS < MIN_REGS) begin : g_bad_regs
      $error("clkctl_regfile: NUM_REGS must cover every word the clock tree decodes");
   end
   if (ADDR_W < SEL_W + 2) begin : g_bad_addr
      $error("clkctl_regfile: ADDR_W too narrow for NUM_REGS words");
   end

   logic                in_range;
   logic [SEL_W-1:0]    sel;
   logic [NUM_REGS-1:0] wr_sel;
   word_t [NUM_REGS-1:0] words;
   logic                wr_acc;
   logic                wr_hit;
   logic                rd_acc;
   logic                bad_acc;

   assign wr_acc = req_valid &  req_write;
   assign rd_acc = req_valid & ~req_write;

   clkctl_addr_dec #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS),
      .SEL_W    (SEL_W)
   ) u_dec (
      .addr_i     (req_addr),
      .wr_acc_i   (wr_acc),
      .in_range_o (in_range),
      .sel_o      (sel),
      .wr_sel_o   (wr_sel)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      localparam reg_attr_t ATTR = reg_attr(i);
      if (ATTR.wr_en) begin : g_rw
         clkctl_word #(
            .RST_VAL    (ATTR.rst),
            .WR_MASK    (ATTR.mask),
            .FORCE_ONES (ATTR.force1)
         ) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr_sel[i]),
            .wdata_i (req_wdata),
            .q_o     (words[i])
         );
      end else begin : g_ro
         assign words[i] = ATTR.rst;
      end
   end

   assign wr_hit  = |wr_sel;
   assign bad_acc = req_valid & (req_write ? ~wr_hit : ~in_range);

   clkctl_resp #(
      .NUM_REGS (NUM_REGS),
      .SEL_W    (SEL_W)
   ) u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_i       (rd_acc),
      .in_range_i (in_range),
      .sel_i      (sel),
      .words_i    (words),
      .bad_i      (bad_acc),
      .rdata_o    (rsp_rdata),
      .err_o      (rsp_err)
   );

   assign clk_mode_o     = words[IDX_MODE];
   assign clk_div_a_o    = words[IDX_DIV_A];
   assign clk_div_b_o    = words[IDX_DIV_B];
   assign clk_pll_main_o = words[IDX_PLL_MAIN];
   assign clk_pll_sys_o  = words[IDX_PLL_SYS];
   assign clk_gate_o     = {words[IDX_GATE2], words[IDX_GATE1], words[IDX_GATE0]};

endmodule

// File: rtl/clkctl_regfile_chk.sv
module clkctl_regfile_chk
   import clkctl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned NUM_REGS = 26
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         req_valid,
   input logic                         req_write,
   input logic [ADDR_W-1:0]            req_addr,
   input logic [WORD_W-1:0]            req_wdata,
   input logic [WORD_W-1:0]            rsp_rdata,
   input logic                         rsp_err,
   input logic [WORD_W-1:0]            clk_mode_o,
   input logic [WORD_W-1:0]            clk_div_a_o,
   input logic [WORD_W-1:0]            clk_div_b_o,
   input logic [WORD_W-1:0]            clk_pll_main_o,
   input logic [WORD_W-1:0]            clk_pll_sys_o,
   input logic [GATE_WORDS*WORD_W-1:0] clk_gate_o
);

   logic [ADDR_W-3:0] c_idx;
   logic              unused_lo;
   logic              c_legal_wr;
   logic [(5+GATE_WORDS)*WORD_W-1:0] c_tree;

   assign c_idx      = req_addr[ADDR_W-1:2];
   assign unused_lo  = ^req_addr[1:0];
   assign c_legal_wr = (32'(c_idx) inside {0, 1, 2, 4, 6, 8, 9, 10});
   assign c_tree     = {clk_mode_o, clk_div_a_o, clk_div_b_o,
                        clk_pll_main_o, clk_pll_sys_o, clk_gate_o};

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_err && $stable(rsp_rdata));

   p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $past(req_valid));

   p_bad_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && !c_legal_wr |=> rsp_err && $stable(c_tree));

   p_mode_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && (32'(c_idx) == 0) |=>
         !rsp_err && clk_mode_o[MODE_FORCE_BIT] &&
         ((clk_mode_o & MODE_WR_MASK) == ($past(req_wdata) & MODE_WR_MASK)));

   p_pll_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && (32'(c_idx) == 4) |=>
         ((clk_pll_main_o & ~PLL_WR_MASK) == '0));

   p_div_b_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && (32'(c_idx) == 2) |=> clk_div_b_o == $past(req_wdata));

   p_oob_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && (32'(c_idx) >= NUM_REGS) |=> rsp_err && (rsp_rdata == '0));

endmodule

bind clkctl_regfile clkctl_regfile_chk #(
   .ADDR_W   (ADDR_W),
   .NUM_REGS (NUM_REGS)
) u_chk (.*);

// File: tb/sim_clkctl_regfile.sv
`timescale 1ns/1ps
module sim_clkctl_regfile;

   localparam int unsigned AW = 12;
   localparam int NR = 26;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic [31:0]   rsp_rdata;
   logic          rsp_err;
   logic [31:0]   clk_mode_o, clk_div_a_o, clk_div_b_o, clk_pll_main_o, clk_pll_sys_o;
   logic [95:0]   clk_gate_o;

   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;

   logic [31:0] mdl [NR];
   logic [31:0] exp_rdata;
   logic        exp_err;

   always #2 clk = ~clk;

   clkctl_regfile #(.ADDR_W(AW), .NUM_REGS(NR)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .clk_mode_o(clk_mode_o), .clk_div_a_o(clk_div_a_o),
      .clk_div_b_o(clk_div_b_o), .clk_pll_main_o(clk_pll_main_o),
      .clk_pll_sys_o(clk_pll_sys_o), .clk_gate_o(clk_gate_o)
   );

   function automatic logic [31:0] boot_val(int i);
      case (i)
         0:             return 32'h074b_0b7d;
         1:             return 32'hff87_0b48;
         8, 9, 10, 11:  return 32'hffff_ffff;
         default:       return 32'h0;
      endcase
   endfunction

   function automatic bit is_wr(int i);
      return (i inside {0, 1, 2, 4, 6, 8, 9, 10});
   endfunction

   function logic [255:0] model_tree();
      return {mdl[0], mdl[1], mdl[2], mdl[4], mdl[6], mdl[10], mdl[9], mdl[8]};
   endfunction

   task automatic check(string tag, logic [255:0] act, logic [255:0] exp, string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      check(tag, 256'(rsp_rdata), 256'(exp_rdata), "rdata");
      check(tag, 256'(rsp_err), 256'(exp_err), "err");
      check(tag, {clk_mode_o, clk_div_a_o, clk_div_b_o, clk_pll_main_o,
                  clk_pll_sys_o, clk_gate_o}, model_tree(), "clock tree");
   endtask

   // One bus cycle: drive at a falling edge, model the rising edge, compare at the next falling edge.
   task automatic step(logic v, logic w, logic [AW-1:0] a, logic [31:0] d, string tag);
      int idx;
      req_valid = v;
      req_write = w;
      req_addr  = a;
      req_wdata = d;
      idx = int'(a >> 2);
      @(posedge clk);
      exp_err = 1'b0;
      if (v && !w) begin
         if (idx < NR) exp_rdata = mdl[idx];
         else begin
            exp_rdata = 32'h0;
            exp_err   = 1'b1;
         end
      end else if (v && w) begin
         case (idx)
            0:             mdl[0] = (d & 32'h3b6f_dfff) | 32'h0400_0000;
            1:             mdl[1] = d & 32'hff9f_3fff;
            4, 6:          mdl[idx] = d & 32'hbfff_3fff;
            2, 8, 9, 10:   mdl[idx] = d;
            default:       exp_err = 1'b1;
         endcase
      end
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic read_all(string tag);
      for (int i = 0; i < NR; i++) step(1'b1, 1'b0, AW'(i * 4), 32'h0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] pats [5];
      pats = '{32'hffff_ffff, 32'h0000_0000, 32'ha5a5_a5a5, 32'h5a5a_5a5a, 32'h1234_5678};
      for (int i = 0; i < NR; i++) mdl[i] = boot_val(i);
      exp_rdata = 32'h0;
      exp_err   = 1'b0;

      repeat (3) @(negedge clk);
      check_all("R1");   // state held in reset
      rst_n = 1'b1;
      step(1'b0, 1'b0, '0, 32'h0, "R11");

      read_all("R1");    // R1 reset contents, R3 one-cycle read

      // R4: reads past the last word, including the spare select codes
      for (int i = NR; i < 32; i++) step(1'b1, 1'b0, AW'(i * 4), 32'h0, "R4");
      step(1'b1, 1'b0, 12'hffc, 32'h0, "R4");
      step(1'b1, 1'b0, 12'h800, 32'h0, "R4");

      // R5 R6 R7: masked and full writes with several patterns, then read back (R3, R10)
      foreach (pats[p]) begin
         step(1'b1, 1'b1, 12'h000, pats[p], "R5");
         step(1'b1, 1'b0, 12'h000, 32'h0,   "R5");
         step(1'b1, 1'b1, 12'h004, pats[p], "R6");
         step(1'b1, 1'b1, 12'h010, pats[p], "R6");
         step(1'b1, 1'b1, 12'h018, ~pats[p], "R6");
         step(1'b1, 1'b1, 12'h008, pats[p], "R7");
         step(1'b1, 1'b1, 12'h020, pats[p] ^ 32'h0f0f_0001, "R7");
         step(1'b1, 1'b1, 12'h024, ~pats[p], "R7");
         step(1'b1, 1'b1, 12'h028, pats[p] + 32'd7, "R7");
         read_all("R3");
      end

      // R8: writes to read-only and unknown offsets change nothing
      for (int i = 0; i < 32; i++) begin
         if (!is_wr(i)) step(1'b1, 1'b1, AW'(i * 4), 32'hdead_beef, "R8");
      end
      step(1'b1, 1'b1, 12'hffc, 32'h0bad_f00d, "R8");
      step(1'b1, 1'b1, 12'h068, 32'h0, "R8");
      read_all("R8");

      // R2: low address bits ignored
      step(1'b1, 1'b1, 12'h009, 32'hcafe_0001, "R2");
      step(1'b1, 1'b0, 12'h00b, 32'h0, "R2");
      step(1'b1, 1'b1, 12'h023, 32'h0000_fffe, "R2");
      step(1'b1, 1'b0, 12'h022, 32'h0, "R2");
      step(1'b1, 1'b1, 12'h00e, 32'h0, "R2");   // index 3, read-only
      step(1'b1, 1'b0, 12'h066, 32'h0, "R2");   // index 25

      // R3: read data holds across idle and write cycles
      step(1'b1, 1'b0, 12'h004, 32'h0, "R3");
      step(1'b0, 1'b0, 12'h000, 32'h0, "R3");
      step(1'b1, 1'b1, 12'h008, 32'h7777_8888, "R3");
      step(1'b0, 1'b1, 12'h0fc, 32'h0, "R3");

      // R9: back-to-back errors, then an accepted access clears the pulse
      step(1'b1, 1'b1, 12'h00c, 32'h1, "R9");
      step(1'b1, 1'b0, 12'h070, 32'h0, "R9");
      step(1'b1, 1'b1, 12'h010, 32'h2, "R9");
      step(1'b1, 1'b0, 12'h00c, 32'h0, "R9");
      step(1'b0, 1'b0, 12'h000, 32'h0, "R9");

      // R10: clock tree tracks each exposed word from the next cycle
      step(1'b1, 1'b1, 12'h018, 32'h0fed_cba9, "R10");
      step(1'b1, 1'b1, 12'h028, 32'h8000_0001, "R10");

      // R11: valid low with write data aimed at writable words
      step(1'b0, 1'b1, 12'h000, 32'h0000_0000, "R11");
      step(1'b0, 1'b1, 12'h020, 32'h1357_9bdf, "R11");
      step(1'b0, 1'b0, 12'hffc, 32'h0, "R11");
      read_all("R11");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule